// File: doc/BRIEF.md
# CAN Nominal Bit Timing Unit

This block holds the bit-timing configuration of a CAN controller and turns it into a running time base. Software programs a quantum prescaler, a jump-width value and two time segments through a small write port. The block then emits a one-cycle time-quantum enable and steps through the three parts of a nominal bit: the sync quantum, the first segment (propagation plus phase 1) and the second segment (phase 2). A one-cycle sample strobe marks the end of the first segment and a one-cycle bit-end strobe marks the end of the second segment. The protocol engine uses these strobes to sample the bus and to advance to the next bit.

The timing registers are protected. They accept writes only while the control register has both its halt bit and its configuration-unlock bit set. While the halt bit is set, the time base is frozen in a halt state. When the halt bit is cleared, counting begins again at the sync quantum. Edge resynchronisation and bit stuffing are handled elsewhere. The jump width is stored and presented on a port but does not act on the counters.

The segment machine has four states, with state code in parentheses:
- HALT (0): the halt bit is set.
- SYNC (1): the single sync quantum.
- PH1 (2): the first segment.
- PH2 (3): the second segment.

It makes these transitions:
- HALT to SYNC on the edge after the halt bit reads clear.
- SYNC to PH1 at the end of the sync quantum.
- PH1 to PH2 at the end of the last first-segment quantum.
- PH2 to SYNC at the end of the last second-segment quantum.
- Any state to HALT on the edge after the halt bit reads set.

Top module: `cbt_top`

## Requirements
- R1: After reset the readbacks are as follows: halt bit 1, unlock bit 0, timing register 16'h2301, extension register 0, segment state HALT. No quantum enable or strobe is active.
- R2: A write to address 1 (timing) or address 2 (extension) takes effect when the control register currently has bit 0 (halt) and bit 6 (unlock) both set. A write to address 0 always loads halt from data bit 0 and unlock from data bit 6.
- R3: A timing or extension write made while halt or unlock is clear is ignored, and both readbacks keep their previous values.
- R4: The timing register fields are as follows: prescaler low bits [5:0], jump width [7:6], first segment [11:8], second segment [14:12]. Bit 15 reads 0. The extension register stores data bits [3:0] as prescaler bits [9:6]. The jump width appears on the `sjw` port.
- R5: Every field stores its value minus one. The quantum enable pulses once every P = {ext, prescaler low} + 1 clocks. The first pulse comes P clocks after the machine leaves HALT.
- R6: A bit lasts 1 + (T1 + 1) + (T2 + 1) quanta, where T1 and T2 are the effective segment fields.
- R7: The sample strobe is high for one cycle, coinciding with the quantum enable that ends the last quantum of the first segment, while the state is PH1.
- R8: The bit-end strobe is high for one cycle, coinciding with the quantum enable that ends the last quantum of the second segment, while the state is PH2. The next state is SYNC.
- R9: While the halt bit is set, no quantum enable or strobe is produced and the state reads HALT. After halt clears, the state reads SYNC one cycle later.
- R10: The segment state output uses the encoding HALT=0, SYNC=1, PH1=2, PH2=3.
- R11: A first-segment field of 0 behaves as 1, so the first segment is never shorter than 2 quanta. A second-segment field of 0 gives 1 quantum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 control, 1 timing, 2 extension |
| wr_data | input | 16 | Write data |
| rd_halt | output | 1 | Control halt bit |
| rd_unlock | output | 1 | Control configuration-unlock bit |
| rd_timing | output | 16 | Timing register readback |
| rd_ext | output | 4 | Extension register readback |
| sjw | output | 2 | Stored jump width (value minus one) |
| tq_en | output | 1 | Time-quantum enable pulse |
| seg_state | output | 2 | Current segment state code |
| sample_strobe | output | 1 | End of first segment |
| bit_end_strobe | output | 1 | End of second segment |

## Verification
The embedded properties assume that the prescaler and segment values change only while the halt bit is set. The register gate guarantees this, so no property accounts for configuration moving under a running count. The stimulus reprograms timing only from the halted, unlocked state. Its one write attempt during a run is expected to be dropped. A run is stopped only between a bit end and the next sample point, so every predicted strobe is reached before the halt takes hold.

// File: rtl/cbt_pkg.sv
package cbt_pkg;

    localparam int BRP_LO_W = 6;
    localparam int SJW_W    = 2;
    localparam int TS1_W    = 4;
    localparam int TS2_W    = 3;
    localparam int EXT_W    = 4;
    localparam int PRE_W    = BRP_LO_W + EXT_W;
    localparam int QCNT_W   = (TS1_W > TS2_W) ? TS1_W : TS2_W;

    typedef struct packed {
        logic [TS2_W-1:0]    ts2;
        logic [TS1_W-1:0]    ts1;
        logic [SJW_W-1:0]    sjw;
        logic [BRP_LO_W-1:0] brp;
    } timing_t;

    localparam int TIM_W = $bits(timing_t);

    typedef enum logic [1:0] {
        SEG_HALT = 2'd0,
        SEG_SYNC = 2'd1,
        SEG_PH1  = 2'd2,
        SEG_PH2  = 2'd3
    } seg_state_e;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_TIMING = 2'd1;
    localparam logic [1:0] ADDR_EXT    = 2'd2;

    localparam int CTRL_HALT_BIT   = 0;
    localparam int CTRL_UNLOCK_BIT = 6;

endpackage

// File: rtl/cbt_regs.sv
module cbt_regs
    import cbt_pkg::*;
#(
    parameter int             DATA_W    = 16,
    parameter logic [TIM_W-1:0] TIM_RESET = 15'h2301,
    parameter logic [EXT_W-1:0] EXT_RESET = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              halt_q,
    output logic              unlock_q,
    output timing_t           tim_q,
    output logic [EXT_W-1:0]  ext_q
);

    logic open_gate;

    // configuration may change only while halted and unlocked
    assign open_gate = halt_q && unlock_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            halt_q   <= 1'b1;
            unlock_q <= 1'b0;
            tim_q    <= timing_t'(TIM_RESET);
            ext_q    <= EXT_RESET;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_CTRL: begin
                    halt_q   <= wr_data[CTRL_HALT_BIT];
                    unlock_q <= wr_data[CTRL_UNLOCK_BIT];
                end
                ADDR_TIMING: begin
                    if (open_gate) tim_q <= timing_t'(wr_data[TIM_W-1:0]);
                end
                ADDR_EXT: begin
                    if (open_gate) ext_q <= wr_data[EXT_W-1:0];
                end
                default: ;
            endcase
        end
    end

    // R3: a locked register file keeps its timing contents
    a_r3_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(halt_q && unlock_q) |=> ($stable(tim_q) && $stable(ext_q)));

endmodule

// File: rtl/cbt_prescaler.sv
module cbt_prescaler #(
    parameter int PW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [PW-1:0] presc,
    output logic          tq_en
);

    logic [PW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt == presc) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tq_en = run && (cnt == presc);

    // R5: counter never runs past the programmed terminal value
    a_r5_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= presc));

    // R5: with a prescaler above zero, pulses are separated
    a_r5_pulse_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (tq_en && presc != '0) |=> !tq_en);

endmodule

// File: rtl/cbt_seg_fsm.sv
module cbt_seg_fsm
    import cbt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt_q,
    input  logic             tq_en,
    input  logic [TS1_W-1:0] ts1_eff,
    input  logic [TS2_W-1:0] ts2,
    output seg_state_e       state,
    output logic             run,
    output logic             sample,
    output logic             bit_end
);

    seg_state_e        nstate;
    logic [QCNT_W-1:0] qcnt;
    logic [QCNT_W-1:0] nqcnt;
    logic              ph1_last;
    logic              ph2_last;

    assign ph1_last = (qcnt == QCNT_W'(ts1_eff));
    assign ph2_last = (qcnt == QCNT_W'(ts2));

    always_comb begin
        nstate = state;
        nqcnt  = qcnt;
        unique case (state)
            SEG_HALT: begin
                if (!halt_q) begin
                    nstate = SEG_SYNC;
                    nqcnt  = '0;
                end
            end
            SEG_SYNC: begin
                if (tq_en) begin
                    nstate = SEG_PH1;
                    nqcnt  = '0;
                end
            end
            SEG_PH1: begin
                if (tq_en) begin
                    if (ph1_last) begin
                        nstate = SEG_PH2;
                        nqcnt  = '0;
                    end else begin
                        nqcnt = qcnt + 1'b1;
                    end
                end
            end
            SEG_PH2: begin
                if (tq_en) begin
                    if (ph2_last) begin
                        nstate = SEG_SYNC;
                        nqcnt  = '0;
                    end else begin
                        nqcnt = qcnt + 1'b1;
                    end
                end
            end
        endcase
        if (halt_q) begin
            nstate = SEG_HALT;
            nqcnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SEG_HALT;
            qcnt  <= '0;
        end else begin
            state <= nstate;
            qcnt  <= nqcnt;
        end
    end

    always_comb begin
        run     = (state != SEG_HALT) && !halt_q;
        sample  = tq_en && (state == SEG_PH1) && ph1_last;
        bit_end = tq_en && (state == SEG_PH2) && ph2_last;
    end

    // R7: sample strobe lasts a single cycle
    a_r7_sample_single: assert property (@(posedge clk) disable iff (!rst_n)
        sample |=> !sample);

    // R7 / R8: the two strobes never coincide
    a_r8_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sample, bit_end}));

    // R8: a bit end is followed by the sync quantum
    a_r8_end_to_sync: assert property (@(posedge clk) disable iff (!rst_n)
        bit_end |=> (state == SEG_SYNC));

    // R9: nothing ticks while halted
    a_r9_quiet_in_halt: assert property (@(posedge clk) disable iff (!rst_n)
        halt_q |-> (!tq_en && !sample && !bit_end));

    // R9: release from halt enters sync
    a_r9_restart_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEG_HALT && !halt_q) |=> (state == SEG_SYNC));

endmodule

// File: rtl/cbt_top.sv
module cbt_top
    import cbt_pkg::*;
#(
    parameter int              DATA_W    = 16,
    parameter logic [TIM_W-1:0] TIM_RESET = 15'h2301,
    parameter logic [EXT_W-1:0] EXT_RESET = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              rd_halt,
    output logic              rd_unlock,
    output logic [DATA_W-1:0] rd_timing,
    output logic [EXT_W-1:0]  rd_ext,
    output logic [SJW_W-1:0]  sjw,
    output logic              tq_en,
    output logic [1:0]        seg_state,
    output logic              sample_strobe,
    output logic              bit_end_strobe
);

    timing_t          tim_q;
    logic [EXT_W-1:0] ext_q;
    logic             halt_q;
    logic             unlock_q;
    logic [PRE_W-1:0] presc;
    logic [TS1_W-1:0] ts1_eff;
    logic             run;
    seg_state_e       state;

    cbt_regs #(
        .DATA_W   (DATA_W),
        .TIM_RESET(TIM_RESET),
        .EXT_RESET(EXT_RESET)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .halt_q  (halt_q),
        .unlock_q(unlock_q),
        .tim_q   (tim_q),
        .ext_q   (ext_q)
    );

    assign presc   = {ext_q, tim_q.brp};
    // first segment is clamped to at least two quanta
    assign ts1_eff = (tim_q.ts1 == '0) ? TS1_W'(1) : tim_q.ts1;

    cbt_prescaler #(
        .PW(PRE_W)
    ) u_presc (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .presc(presc),
        .tq_en(tq_en)
    );

    cbt_seg_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .halt_q (halt_q),
        .tq_en  (tq_en),
        .ts1_eff(ts1_eff),
        .ts2    (tim_q.ts2),
        .state  (state),
        .run    (run),
        .sample (sample_strobe),
        .bit_end(bit_end_strobe)
    );

    assign rd_halt   = halt_q;
    assign rd_unlock = unlock_q;
    assign rd_timing = DATA_W'(tim_q);
    assign rd_ext    = ext_q;
    assign sjw       = tim_q.sjw;
    assign seg_state = state;

    // R10: sample only inside the first segment, bit end only inside the second
    a_r10_strobe_states: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_strobe |-> seg_state == 2'd2) and (bit_end_strobe |-> seg_state == 2'd3));

endmodule

// File: tb/cbt_top_test.sv
`timescale 1ns/1ps
module cbt_top_test;

    typedef struct {
        int kind;   // 0 sample, 1 bit end
        int cyc;
        int quanta;
        int seg;
    } ev_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        rd_halt, rd_unlock;
    logic [15:0] rd_timing;
    logic [3:0]  rd_ext;
    logic [1:0]  sjw;
    logic        tq_en;
    logic [1:0]  seg_state;
    logic        sample_strobe, bit_end_strobe;

    int  n_chk = 0;
    int  n_bad = 0;
    int  cyc = 0;
    int  qcount = 0;
    bit  halted = 1'b1;
    ev_t expq[$];

    always #10 clk = ~clk;

    cbt_top uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_halt(rd_halt), .rd_unlock(rd_unlock), .rd_timing(rd_timing), .rd_ext(rd_ext),
        .sjw(sjw), .tq_en(tq_en), .seg_state(seg_state),
        .sample_strobe(sample_strobe), .bit_end_strobe(bit_end_strobe)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check_eq(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // monitor: pops predicted strobes and compares them
    always @(negedge clk) begin
        if (rst_n) begin
            if (halted) begin
                qcount = 0;
                if (tq_en || sample_strobe || bit_end_strobe)
                    check_eq("R9 quiet while halted", 1, 0);
            end else begin
                if (tq_en) qcount++;
                if (sample_strobe || bit_end_strobe) begin
                    if (expq.size() == 0) begin
                        check_eq("R7/R8 unexpected strobe at cycle", cyc, -1);
                    end else begin
                        ev_t e;
                        e = expq.pop_front();
                        check_eq(e.kind == 0 ? "R7 sample strobe kind" : "R8 bit-end strobe kind",
                                 bit_end_strobe ? 1 : 0, e.kind);
                        check_eq("R5 strobe cycle", cyc, e.cyc);
                        check_eq("R6 quanta count", qcount, e.quanta);
                        check_eq("R10 segment state at strobe", seg_state, e.seg);
                    end
                    if (bit_end_strobe) qcount = 0;
                end
            end
        end
    end

    initial begin
        for (int w = 0; w < 200000; w++) @(posedge clk);
        check_eq("watchdog expired", 1, 0);
        finish_up();
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_cfg(input int brp10, input int ts1, input int ts2, input int sjwv,
                           input int nbits, input bit poke);
        int p, t1, n, e0, e1;
        logic [15:0] tv;
        p  = brp10 + 1;
        t1 = (ts1 == 0) ? 1 : ts1;     // R11 clamp
        n  = 1 + (t1 + 1) + (ts2 + 1);
        tv = {1'b0, 3'(ts2), 4'(ts1), 2'(sjwv), 6'(brp10 & 63)};
        wr(2'd1, tv);
        wr(2'd2, 16'(brp10 >> 6));
        check_eq("R2 timing write accepted", rd_timing, tv);
        check_eq("R2 extension write accepted", rd_ext, brp10 >> 6);
        check_eq("R4 jump width port", sjw, sjwv);
        @(negedge clk);
        e0 = cyc + 1;
        e1 = e0 + 1;
        for (int b = 0; b < nbits; b++) begin
            expq.push_back('{0, e1 + (b * n + t1 + 2) * p - 1, t1 + 2, 2});
            expq.push_back('{1, e1 + (b + 1) * n * p - 1, n, 3});
        end
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 16'h0040;   // halt=0, unlock=1
        @(posedge clk); #1;
        halted = 1'b0;
        wr_en = 1'b0;
        @(negedge clk);
        check_eq("R9 still halt on release edge", seg_state, 0);
        @(negedge clk);
        check_eq("R9 restart in sync", seg_state, 1);
        if (poke) begin
            wr(2'd1, 16'h0000);
            check_eq("R3 timing write ignored while running", rd_timing, tv);
            wr(2'd2, 16'h000F);
            check_eq("R3 extension write ignored while running", rd_ext, brp10 >> 6);
        end
        while (expq.size() != 0) @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 16'h0041;   // halt=1, unlock=1
        @(posedge clk); #1;
        halted = 1'b1;
        wr_en = 1'b0;
        repeat (6) @(negedge clk);
        check_eq("R9 halt state after stop", seg_state, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_eq("R1 tq_en low in reset", tq_en, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1 halt bit", rd_halt, 1);
        check_eq("R1 unlock bit", rd_unlock, 0);
        check_eq("R1 timing reset", rd_timing, 16'h2301);
        check_eq("R1 extension reset", rd_ext, 0);
        check_eq("R1 R10 state HALT", seg_state, 0);
        // locked: halted but not unlocked
        wr(2'd1, 16'h1111);
        check_eq("R3 timing ignored when locked", rd_timing, 16'h2301);
        wr(2'd2, 16'h0005);
        check_eq("R3 extension ignored when locked", rd_ext, 0);
        wr(2'd0, 16'h0041);
        check_eq("R2 control unlock", rd_unlock, 1);
        // field layout
        wr(2'd1, 16'hFFFF);
        check_eq("R4 bit 15 reads zero", rd_timing, 16'h7FFF);
        check_eq("R4 jump width field", sjw, 3);
        wr(2'd2, 16'h00FF);
        check_eq("R4 extension width", rd_ext, 4'hF);
        wr(2'd1, 16'h2C80);
        check_eq("R4 field positions", sjw, 2);
        // timing runs
        run_cfg(0, 2, 1, 2, 3, 1'b1);      // P=1
        run_cfg(67, 1, 0, 1, 2, 1'b0);     // split prescaler, R5
        run_cfg(1, 0, 2, 0, 3, 1'b0);      // R11 clamp of first segment
        run_cfg(2, 15, 7, 3, 2, 1'b0);     // longest segments
        finish_up();
    end

endmodule